// File: doc/BRIEF.md
# Effective Address Generator

This block sits in a load/store pipeline stage and turns an instruction's operand fields into either a memory address or a plain operand. A mode code picks how the result is formed. The inputs are a base register value, an index register value, a sign-extended constant, a two-bit scale code and the program counter of the current instruction.

Seven of the eight modes finish in one cycle. Their result is registered and shown with a one-cycle valid strobe.

The memory-indirect mode first has to fetch a pointer. It sends one read through a small request/response port, holds a busy flag while it waits, and presents the returned word as the final address on the cycle after the response. New requests are taken only while the block is idle. All arithmetic is 32-bit and wraps around with no overflow indication.

Top module: `agu_ea_unit`

## Requirements
- R1: While reset is held, and on the first cycle after it, `res_valid`, `busy` and `mrd_req` are low.
- R2: Mode code 0 (register) returns `base_val` and mode code 1 (immediate) returns `const_val`. For both, `res_is_addr` is 0 and no memory read is issued.
- R3: Mode code 2 (displacement) returns `base_val + const_val` modulo 2^32.
- R4: Mode code 3 (register indirect) returns `base_val` unchanged. Mode code 4 (absolute) returns `const_val` unchanged.
- R5: Mode code 6 (PC-relative) returns `pc_val + const_val` modulo 2^32.
- R6: Mode code 7 (scaled) returns `base_val + (index_val << scale_sel) + const_val` modulo 2^32. Scale codes 0, 1, 2 and 3 give factors 1, 2, 4 and 8.
- R7: A request is accepted when `req_valid` is high and `busy` is low.
  - For every mode except 5, `res_valid` is high only on the cycle right after acceptance, for exactly one cycle.
  - No memory read is issued for these modes.
- R8: When mode code 5 (memory indirect) is accepted, on the next cycle:
  - `mrd_req` is high for exactly one cycle, with `mrd_addr = base_val`.
  - `busy` goes high and stays high until the cycle on which `mrd_resp_valid` is seen.
  - `res_valid` stays low throughout.
- R9: On the cycle after `mrd_resp_valid` is seen during a memory-indirect wait:
  - `res_valid` is high and `res_value` equals the `mrd_resp_data` that came with the response.
  - `busy` is low.
- R10: A request presented while `busy` is high is ignored. It produces no result, starts no read and does not change the pending result.
- R11: `res_is_addr` is 1 for every mode except codes 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_mode | input | 3 | Addressing mode code |
| base_val | input | 32 | Base register value |
| index_val | input | 32 | Index register value |
| const_val | input | 32 | Sign-extended displacement or immediate |
| scale_sel | input | 2 | Scale code, shift amount for the index |
| pc_val | input | 32 | Program counter of the current instruction |
| busy | output | 1 | Pointer fetch in progress; requests ignored |
| mrd_req | output | 1 | Pointer read request pulse |
| mrd_addr | output | 32 | Pointer read address |
| mrd_resp_valid | input | 1 | Pointer read response strobe |
| mrd_resp_data | input | 32 | Pointer read response word |
| res_valid | output | 1 | Result strobe |
| res_value | output | 32 | Final address or operand |
| res_is_addr | output | 1 | Result is an address (1) or an operand (0) |

## Verification
Every mode is driven with all-zero fields, with a base or index of all ones plus a constant that forces a carry past bit 31, and with pseudo-random fields under all four scale codes. Together these show that each mode picks the right sources, that the sums wrap correctly, and that the scale shifts by the right amount.

The memory-indirect mode is run with response delays of zero to three cycles. Stray requests and stray responses are injected during and outside the wait. These runs separate correct busy timing, one-shot read issue and the pointer hand-back from requests that leak through while the block is busy.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [2:0] {
    AM_REG    = 3'd0,
    AM_IMM    = 3'd1,
    AM_DISP   = 3'd2,
    AM_RIND   = 3'd3,
    AM_ABS    = 3'd4,
    AM_MIND   = 3'd5,
    AM_PCREL  = 3'd6,
    AM_SCALED = 3'd7
  } agu_mode_e;

  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_WAIT = 1'b1
  } seq_state_e;
endpackage

// File: rtl/agu_scale_shift.sv
module agu_scale_shift #(
  parameter int W       = 32,
  parameter int SCALE_W = 2
) (
  input  logic [W-1:0]       idx_in,
  input  logic [SCALE_W-1:0] scale_in,
  output logic [W-1:0]       idx_scaled
);
  localparam int NSTEP = SCALE_W;
  logic [W-1:0] stage [0:NSTEP];

  assign stage[0] = idx_in;

  // One shift stage per bit of the scale code; no multiplier is involved.
  for (genvar s = 0; s < NSTEP; s++) begin : g_stage
    assign stage[s+1] = scale_in[s] ? (stage[s] << (1 << s)) : stage[s];
  end

  assign idx_scaled = stage[NSTEP];
endmodule

// File: rtl/agu_mode_calc.sv
module agu_mode_calc
  import agu_pkg::*;
#(
  parameter int W       = 32,
  parameter int SCALE_W = 2
) (
  input  logic [2:0]         mode,
  input  logic [W-1:0]       base,
  input  logic [W-1:0]       index,
  input  logic [W-1:0]       cval,
  input  logic [SCALE_W-1:0] scale,
  input  logic [W-1:0]       pc,
  output logic [W-1:0]       value,
  output logic               is_addr,
  output logic               needs_mem
);
  logic [W-1:0] idx_sh;
  logic [W-1:0] base_plus_c;

  agu_scale_shift #(.W(W), .SCALE_W(SCALE_W)) u_shift (
    .idx_in    (idx_sh_src),
    .scale_in  (scale),
    .idx_scaled(idx_sh)
  );

  logic [W-1:0] idx_sh_src;
  assign idx_sh_src  = index;
  assign base_plus_c = base + cval;

  always_comb begin
    value     = '0;
    is_addr   = 1'b1;
    needs_mem = 1'b0;
    unique case (agu_mode_e'(mode))
      AM_REG:    begin value = base; is_addr = 1'b0; end
      AM_IMM:    begin value = cval; is_addr = 1'b0; end
      AM_DISP:   value = base_plus_c;
      AM_RIND:   value = base;
      AM_ABS:    value = cval;
      AM_MIND:   begin value = base; needs_mem = 1'b1; end
      AM_PCREL:  value = pc + cval;
      AM_SCALED: value = base_plus_c + idx_sh;
      default:   value = '0;
    endcase
  end
endmodule

// File: rtl/agu_indirect_seq.sv
module agu_indirect_seq
  import agu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] ptr_addr,
  input  logic         resp_valid,
  input  logic [W-1:0] resp_data,
  output logic         busy,
  output logic         rd_req,
  output logic [W-1:0] rd_addr,
  output logic         done,
  output logic [W-1:0] done_data
);
  seq_state_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SQ_IDLE;
      rd_req  <= 1'b0;
      rd_addr <= '0;
    end else begin
      rd_req <= 1'b0;
      unique case (state)
        SQ_IDLE: if (start) begin
          state   <= SQ_WAIT;
          rd_req  <= 1'b1;
          rd_addr <= ptr_addr;
        end
        SQ_WAIT: if (resp_valid) state <= SQ_IDLE;
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign busy      = (state == SQ_WAIT);
  assign done      = busy && resp_valid;
  assign done_data = resp_data;
endmodule

// File: rtl/agu_ea_unit.sv
module agu_ea_unit #(
  parameter int W       = 32,
  parameter int SCALE_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [2:0]         req_mode,
  input  logic [W-1:0]       base_val,
  input  logic [W-1:0]       index_val,
  input  logic [W-1:0]       const_val,
  input  logic [SCALE_W-1:0] scale_sel,
  input  logic [W-1:0]       pc_val,
  output logic               busy,
  output logic               mrd_req,
  output logic [W-1:0]       mrd_addr,
  input  logic               mrd_resp_valid,
  input  logic [W-1:0]       mrd_resp_data,
  output logic               res_valid,
  output logic [W-1:0]       res_value,
  output logic               res_is_addr
);
  logic         accept;
  logic [W-1:0] calc_value;
  logic         calc_is_addr;
  logic         calc_mem;
  logic         seq_done;
  logic [W-1:0] seq_data;

  assign accept = req_valid && !busy;

  agu_mode_calc #(.W(W), .SCALE_W(SCALE_W)) u_calc (
    .mode     (req_mode),
    .base     (base_val),
    .index    (index_val),
    .cval     (const_val),
    .scale    (scale_sel),
    .pc       (pc_val),
    .value    (calc_value),
    .is_addr  (calc_is_addr),
    .needs_mem(calc_mem)
  );

  agu_indirect_seq #(.W(W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (accept && calc_mem),
    .ptr_addr  (calc_value),
    .resp_valid(mrd_resp_valid),
    .resp_data (mrd_resp_data),
    .busy      (busy),
    .rd_req    (mrd_req),
    .rd_addr   (mrd_addr),
    .done      (seq_done),
    .done_data (seq_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid   <= 1'b0;
      res_value   <= '0;
      res_is_addr <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      if (accept && !calc_mem) begin
        res_valid   <= 1'b1;
        res_value   <= calc_value;
        res_is_addr <= calc_is_addr;
      end else if (seq_done) begin
        res_valid   <= 1'b1;
        res_value   <= seq_data;
        res_is_addr <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/agu_ea_checker.sv
module agu_ea_checker #(
  parameter int W       = 32,
  parameter int SCALE_W = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic [2:0]         req_mode,
  input logic [W-1:0]       base_val,
  input logic [W-1:0]       index_val,
  input logic [W-1:0]       const_val,
  input logic [SCALE_W-1:0] scale_sel,
  input logic [W-1:0]       pc_val,
  input logic               busy,
  input logic               mrd_req,
  input logic [W-1:0]       mrd_addr,
  input logic               mrd_resp_valid,
  input logic [W-1:0]       mrd_resp_data,
  input logic               res_valid,
  input logic [W-1:0]       res_value,
  input logic               res_is_addr
);
  logic acc;
  assign acc = req_valid && !busy;

  assert_reg_pass_R2: assert property (@(posedge clk) disable iff (rst)
    (acc && req_mode == 3'd0) |=> (res_value == $past(base_val) && !res_is_addr));

  assert_imm_pass_R2: assert property (@(posedge clk) disable iff (rst)
    (acc && req_mode == 3'd1) |=> (res_value == $past(const_val) && !res_is_addr));

  assert_disp_sum_R3: assert property (@(posedge clk) disable iff (rst)
    (acc && req_mode == 3'd2) |=> res_value == $past(base_val + const_val));

  assert_abs_const_R4: assert property (@(posedge clk) disable iff (rst)
    (acc && req_mode == 3'd4) |=> res_value == $past(const_val));

  assert_pcrel_sum_R5: assert property (@(posedge clk) disable iff (rst)
    (acc && req_mode == 3'd6) |=> res_value == $past(pc_val + const_val));

  assert_scale_unit_R6: assert property (@(posedge clk) disable iff (rst)
    (acc && req_mode == 3'd7 && scale_sel == '0) |=>
      res_value == $past(base_val + index_val + const_val));

  assert_single_cycle_R7: assert property (@(posedge clk) disable iff (rst)
    (acc && req_mode != 3'd5) |=> (res_valid && !mrd_req));

  assert_ptr_read_R8: assert property (@(posedge clk) disable iff (rst)
    (acc && req_mode == 3'd5) |=> (mrd_req && busy && !res_valid && mrd_addr == $past(base_val)));

  assert_read_only_busy_R8: assert property (@(posedge clk) disable iff (rst)
    mrd_req |-> busy);

  assert_busy_no_result_R8: assert property (@(posedge clk) disable iff (rst)
    busy |-> !res_valid);

  assert_ptr_return_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && mrd_resp_valid) |=> (res_valid && !busy && res_is_addr && res_value == $past(mrd_resp_data)));

  assert_busy_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && !mrd_resp_valid) |=> (busy && !mrd_req && !res_valid));
endmodule

bind agu_ea_unit agu_ea_checker #(.W(W), .SCALE_W(SCALE_W)) chk_i (.*);

// File: tb/agu_ea_unit_tb_top.sv
module agu_ea_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_mode = '0;
  logic [31:0] base_val = '0, index_val = '0, const_val = '0, pc_val = '0;
  logic [1:0]  scale_sel = '0;
  logic        busy, mrd_req, res_valid, res_is_addr;
  logic [31:0] mrd_addr, res_value;
  logic        mrd_resp_valid = 1'b0;
  logic [31:0] mrd_resp_data = '0;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #4 clk = ~clk;

  agu_ea_unit dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
    .base_val(base_val), .index_val(index_val), .const_val(const_val),
    .scale_sel(scale_sel), .pc_val(pc_val), .busy(busy), .mrd_req(mrd_req),
    .mrd_addr(mrd_addr), .mrd_resp_valid(mrd_resp_valid),
    .mrd_resp_data(mrd_resp_data), .res_valid(res_valid),
    .res_value(res_value), .res_is_addr(res_is_addr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  function automatic logic [31:0] expect_val(input int m, input logic [31:0] b, input logic [31:0] x,
                                             input logic [31:0] c, input int s, input logic [31:0] p);
    logic [63:0] mult;
    mult = 64'(x) * 64'(32'd1 << s);
    case (m)
      0: return b;
      1: return c;
      2: return b + c;
      3: return b;
      4: return c;
      6: return p + c;
      default: return b + mult[31:0] + c;
    endcase
  endfunction

  function automatic string req_of(input int m);
    case (m)
      0, 1: return "R2";
      2: return "R3";
      3, 4: return "R4";
      6: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic single_req(input int m, input int i);
    logic [31:0] b, x, c, p, e;
    int s;
    s = i % 4;
    if (i == 0) begin b = 0; x = 0; c = 0; p = 0; end
    else if (i == 1) begin b = 32'hFFFF_FFFF; x = 32'hFFFF_FFFF; c = 32'h1; p = 32'hFFFF_FFF0; end
    else if (i == 2) begin b = 32'h8000_0000; x = 32'hF000_0001; c = 32'hFFFF_FFFC; p = 32'h40; end
    else begin b = rnd(); x = rnd(); c = rnd(); p = rnd(); end
    e = expect_val(m, b, x, c, s, p);
    req_valid = 1; req_mode = 3'(m); base_val = b; index_val = x;
    const_val = c; scale_sel = 2'(s); pc_val = p;
    @(negedge clk);
    req_valid = 0;
    chk(res_valid === 1'b1, "R7 valid after accept", 32'(res_valid), 1);
    chk(res_value === e, req_of(m), res_value, e);
    chk(res_is_addr === (m > 1), "R11 address flag", 32'(res_is_addr), 32'(m > 1));
    chk(mrd_req === 1'b0, "R7 no read", 32'(mrd_req), 0);
    @(negedge clk);
    chk(res_valid === 1'b0, "R7 one-cycle strobe", 32'(res_valid), 0);
  endtask

  task automatic indirect_req(input int delay, input logic [31:0] b, input logic [31:0] ptr);
    req_valid = 1; req_mode = 3'd5; base_val = b;
    @(negedge clk);
    req_valid = 0;
    chk(mrd_req === 1'b1 && mrd_addr === b, "R8 read issue", mrd_addr, b);
    chk(busy === 1'b1 && res_valid === 1'b0, "R8 busy set", {30'd0, busy, res_valid}, 32'd2);
    for (int d = 0; d < delay; d++) begin
      // stray request during the wait must be ignored
      req_valid = 1; req_mode = 3'd2; base_val = rnd(); const_val = rnd();
      @(negedge clk);
      req_valid = 0;
      chk(busy === 1'b1 && res_valid === 1'b0 && mrd_req === 1'b0, "R10 ignored while busy",
          {29'd0, busy, res_valid, mrd_req}, 32'd4);
    end
    mrd_resp_valid = 1; mrd_resp_data = ptr;
    @(negedge clk);
    mrd_resp_valid = 0; mrd_resp_data = rnd();
    chk(res_valid === 1'b1 && res_value === ptr, "R9 pointer returned", res_value, ptr);
    chk(busy === 1'b0 && res_is_addr === 1'b1, "R9 busy cleared", {30'd0, busy, res_is_addr}, 32'd1);
    @(negedge clk);
    chk(res_valid === 1'b0, "R9 one-cycle strobe", 32'(res_valid), 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected<100000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(res_valid === 1'b0 && busy === 1'b0 && mrd_req === 1'b0, "R1 in reset",
        {29'd0, res_valid, busy, mrd_req}, 0);
    rst = 0;
    @(negedge clk);
    chk(res_valid === 1'b0 && busy === 1'b0 && mrd_req === 1'b0, "R1 after reset",
        {29'd0, res_valid, busy, mrd_req}, 0);
    // stray response while idle: no effect (R10)
    mrd_resp_valid = 1; mrd_resp_data = 32'hDEAD_BEEF;
    @(negedge clk);
    mrd_resp_valid = 0;
    chk(res_valid === 1'b0, "R10 idle response ignored", 32'(res_valid), 0);
    for (int m = 0; m < 8; m++) begin
      if (m == 5) continue;
      for (int i = 0; i < 40; i++) single_req(m, i);
    end
    for (int d = 0; d < 4; d++) begin
      indirect_req(d, rnd(), rnd());
      indirect_req(d, 32'hFFFF_FFFF, 32'h0);
    end
    // back-to-back: single-cycle request right after indirect completes
    single_req(7, 5);
    finish_run();
  end
endmodule